// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block opens an I2C transfer on behalf of a controller. It takes one request made of a target address and a read/write flag. It checks the address and encodes it. It then hands one or two address bytes to a downstream byte engine, which drives the bus bit by bit. The first byte carries a flag that tells the engine to emit a START condition first. The block never asks the engine for a STOP during the address phase. When the sequence ends, the block raises a one-cycle done pulse. Beside that pulse it reports success, an invalid address, a missing acknowledge, or a timeout passed back from the engine.

The block picks the address form from the value alone. Values below 0x80 are sent as a single 7-bit byte. Values from 0x80 to 0x3FF use the two-byte extended form. Anything larger is refused before any bus activity. A 7-bit value inside the reserved block 0x78..0x7F is also refused. If the first byte of a two-byte address is not acknowledged, the sequence ends there.

Both the request side and the engine command side are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so a request held against back-pressure simply waits. On the command side, `eng_cmd_valid`, `eng_cmd_byte` and `eng_cmd_start` stay unchanged until the engine raises `eng_cmd_ready`. After each accepted command the block waits for `eng_done` before it offers anything else. The result pins are plain status signals.

Top module: `i2c_addr_seq`

## Requirements
- R1: `req_ready` is 1 after reset and whenever the block is idle, and 0 from the accepting edge until the cycle after done. A `req_valid` seen while busy is ignored. No command and no done appear while `req_ready` is 1.
- R2: An address below 0x80 that is not reserved produces exactly one command. Its byte is `{addr[6:0], rd}`, where bit 0 is 1 for read, and `eng_cmd_start` is 1.
- R3: A 7-bit address with bits 6:3 all ones (0x78..0x7F) issues no command. The block gives done with `err_inval` on the cycle after the request is accepted.
- R4: An address of 0x400 or above issues no command. The block gives done with `err_inval` on the cycle after acceptance.
- R5: An address from 0x80 to 0x3FF produces two commands in order. The first is the high byte of `(addr<<1)|rd|0xF000`, which is `{4'hF, 1'b0, addr[9:7]}`, with `eng_cmd_start`=1. The second is the low byte `{addr[6:0], rd}` with `eng_cmd_start`=0.
- R6: `eng_cmd_stop` is 0 on every command.
- R7: While `eng_cmd_valid` is 1 and `eng_cmd_ready` is 0, the command valid, byte and start flag hold steady on the next cycle.
- R8: After a command is accepted, `eng_cmd_valid` is 0 until `eng_done` is seen. Only one command is outstanding at a time.
- R9: If the first byte of a two-byte address ends with nack or timeout, the second byte is not sent, and done carries that error.
- R10: At most one of `err_inval`, `err_nack` and `err_tmo` is 1, and only in the done cycle. When the engine reports nack and timeout together, `err_tmo` wins.
- R11: Done rises the cycle after the `eng_done` of the final byte, and once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | REQ_AW (12) | Target address |
| req_rd | input | 1 | 1 = read, 0 = write |
| eng_cmd_valid | output | 1 | Byte command offered to the engine |
| eng_cmd_ready | input | 1 | Engine takes the command |
| eng_cmd_start | output | 1 | Emit START before this byte |
| eng_cmd_stop | output | 1 | Emit STOP after this byte (always 0) |
| eng_cmd_byte | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine finished the accepted byte |
| eng_nack | input | 1 | Byte was not acknowledged (with eng_done) |
| eng_tmo | input | 1 | Clock stretch timeout (with eng_done) |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_inval | output | 1 | Address refused |
| err_nack | output | 1 | Address byte not acknowledged |
| err_tmo | output | 1 | Engine timeout |

## Verification
The assertions assume an engine that behaves properly. It raises `eng_done` only for a command it has already accepted, and at least one cycle after accepting it. Its `eng_nack` and `eng_tmo` matter only in the cycle that `eng_done` is high. The bench's engine responder follows exactly this pattern. It waits a programmable number of cycles before accepting and before reporting, and it marks chosen byte indices for nack or timeout. Requests are driven for single cycles, with extra pokes while busy, so that the rule of accepting only when ready is exercised and not merely assumed.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE_A,
    ST_WAIT_A,
    ST_ISSUE_B,
    ST_WAIT_B,
    ST_REPORT
  } aseq_state_e;

  typedef enum logic [1:0] {
    RES_OK,
    RES_INVAL,
    RES_NACK,
    RES_TMO
  } aseq_result_e;

  typedef struct packed {
    logic              inval;
    logic              two_byte;
    logic [BYTE_W-1:0] first;
    logic [BYTE_W-1:0] second;
  } aseq_plan_t;

  // Timeout outranks a missing acknowledge.
  function automatic aseq_result_e engine_result(input logic nack, input logic tmo);
    if (tmo) return RES_TMO;
    if (nack) return RES_NACK;
    return RES_OK;
  endfunction
endpackage

// File: rtl/i2c_aseq_encode.sv
module i2c_aseq_encode
  import i2c_aseq_pkg::*;
#(
  parameter int REQ_AW = 12
) (
  input  logic [REQ_AW-1:0] addr,
  input  logic              rd,
  output aseq_plan_t        plan
);
  localparam int SHORT_BITS = 7;
  localparam int LONG_BITS  = 10;
  localparam int RSV_LO     = 3;
  localparam logic [3:0] HI_PREFIX = 4'hF;

  logic over_range;
  logic is_short;
  logic reserved;

  generate
    if (REQ_AW > LONG_BITS) begin : g_wide
      assign over_range = |addr[REQ_AW-1:LONG_BITS];
    end else begin : g_exact
      assign over_range = 1'b0;
    end
  endgenerate

  assign is_short = ~over_range & ~|addr[LONG_BITS-1:SHORT_BITS];
  assign reserved = &addr[SHORT_BITS-1:RSV_LO];

  always_comb begin
    plan.inval    = over_range | (is_short & reserved);
    plan.two_byte = ~is_short;
    plan.second   = {addr[SHORT_BITS-1:0], rd};
    if (is_short) plan.first = {addr[SHORT_BITS-1:0], rd};
    else          plan.first = {HI_PREFIX, 1'b0, addr[LONG_BITS-1:SHORT_BITS]};
  end
endmodule

// File: rtl/i2c_aseq_ctrl.sv
module i2c_aseq_ctrl
  import i2c_aseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  aseq_plan_t        plan_in,
  output logic              req_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_start,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_tmo,
  output logic              seq_done,
  output aseq_result_e      seq_result
);
  aseq_state_e  state;
  aseq_plan_t   plan_q;
  aseq_result_e res_q;
  aseq_result_e eng_res;

  assign eng_res = engine_result(eng_nack, eng_tmo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      plan_q <= '0;
      res_q  <= RES_OK;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          plan_q <= plan_in;
          if (plan_in.inval) begin
            res_q <= RES_INVAL;
            state <= ST_REPORT;
          end else begin
            res_q <= RES_OK;
            state <= ST_ISSUE_A;
          end
        end
        ST_ISSUE_A: if (cmd_ready) state <= ST_WAIT_A;
        ST_WAIT_A: if (eng_done) begin
          res_q <= eng_res;
          if (eng_res == RES_OK && plan_q.two_byte) state <= ST_ISSUE_B;
          else                                     state <= ST_REPORT;
        end
        ST_ISSUE_B: if (cmd_ready) state <= ST_WAIT_B;
        ST_WAIT_B: if (eng_done) begin
          res_q <= eng_res;
          state <= ST_REPORT;
        end
        ST_REPORT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign cmd_valid  = (state == ST_ISSUE_A) || (state == ST_ISSUE_B);
  assign cmd_start  = (state == ST_ISSUE_A);
  assign cmd_byte   = (state == ST_ISSUE_B) ? plan_q.second : plan_q.first;
  assign seq_done   = (state == ST_REPORT);
  assign seq_result = res_q;
endmodule

// File: rtl/i2c_aseq_status.sv
module i2c_aseq_status
  import i2c_aseq_pkg::*;
(
  input  logic         seq_done,
  input  aseq_result_e seq_result,
  output logic         err_inval,
  output logic         err_nack,
  output logic         err_tmo
);
  assign err_inval = seq_done && (seq_result == RES_INVAL);
  assign err_nack  = seq_done && (seq_result == RES_NACK);
  assign err_tmo   = seq_done && (seq_result == RES_TMO);
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
#(
  parameter int REQ_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_AW-1:0] req_addr,
  input  logic              req_rd,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic              eng_cmd_start,
  output logic              eng_cmd_stop,
  output logic [BYTE_W-1:0] eng_cmd_byte,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_tmo,
  output logic              done,
  output logic              err_inval,
  output logic              err_nack,
  output logic              err_tmo
);
  aseq_plan_t   plan;
  aseq_result_e result;

  i2c_aseq_encode #(.REQ_AW(REQ_AW)) u_encode (
    .addr (req_addr),
    .rd   (req_rd),
    .plan (plan)
  );

  i2c_aseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .plan_in    (plan),
    .req_ready  (req_ready),
    .cmd_valid  (eng_cmd_valid),
    .cmd_ready  (eng_cmd_ready),
    .cmd_start  (eng_cmd_start),
    .cmd_byte   (eng_cmd_byte),
    .eng_done   (eng_done),
    .eng_nack   (eng_nack),
    .eng_tmo    (eng_tmo),
    .seq_done   (done),
    .seq_result (result)
  );

  i2c_aseq_status u_status (
    .seq_done   (done),
    .seq_result (result),
    .err_inval  (err_inval),
    .err_nack   (err_nack),
    .err_tmo    (err_tmo)
  );

  // The address phase never closes the transfer.
  assign eng_cmd_stop = 1'b0;
endmodule

// File: rtl/i2c_aseq_chk.sv
module i2c_aseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       eng_cmd_valid,
  input logic       eng_cmd_ready,
  input logic       eng_cmd_start,
  input logic [7:0] eng_cmd_byte,
  input logic       eng_done,
  input logic       done,
  input logic       err_inval,
  input logic       err_nack,
  input logic       err_tmo
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!eng_cmd_valid && !done));

  assert_inval_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_inval) |-> $past(req_valid && req_ready));

  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_byte) && $stable(eng_cmd_start)));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && eng_cmd_ready) |=> !eng_cmd_valid);

  assert_err_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_inval, err_nack, err_tmo}));

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_inval || err_nack || err_tmo) |-> done);

  assert_done_after_engine_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err_inval) |-> $past(eng_done));
endmodule

bind i2c_addr_seq i2c_aseq_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd_ready (eng_cmd_ready),
  .eng_cmd_start (eng_cmd_start),
  .eng_cmd_byte  (eng_cmd_byte),
  .eng_done      (eng_done),
  .done          (done),
  .err_inval     (err_inval),
  .err_nack      (err_nack),
  .err_tmo       (err_tmo)
);

// File: tb/i2c_addr_seq_tb_top.sv
module i2c_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic        req_rd = 1'b0;
  logic        eng_cmd_valid;
  logic        eng_cmd_ready = 1'b0;
  logic        eng_cmd_start;
  logic        eng_cmd_stop;
  logic [7:0]  eng_cmd_byte;
  logic        eng_done = 1'b0;
  logic        eng_nack = 1'b0;
  logic        eng_tmo = 1'b0;
  logic        done;
  logic        err_inval;
  logic        err_nack;
  logic        err_tmo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  i2c_addr_seq #(.REQ_AW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_rd(req_rd), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_ready(eng_cmd_ready), .eng_cmd_start(eng_cmd_start),
    .eng_cmd_stop(eng_cmd_stop), .eng_cmd_byte(eng_cmd_byte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_tmo(eng_tmo),
    .done(done), .err_inval(err_inval), .err_nack(err_nack), .err_tmo(err_tmo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: behavioural, updated at each rising edge.
  bit       m_busy, m_issue, m_wait, m_rep, m_first;
  int       m_err;  // 0 ok, 1 inval, 2 nack, 3 tmo
  bit [7:0] mq[$];
  int       w16;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_issue = 0; m_wait = 0; m_rep = 0; m_first = 0; m_err = 0;
      mq.delete();
    end else if (m_rep) begin
      m_rep = 0; m_busy = 0; m_err = 0;
    end else if (m_issue) begin
      if (eng_cmd_ready) begin m_issue = 0; m_wait = 1; end
    end else if (m_wait) begin
      if (eng_done) begin
        m_wait = 0;
        void'(mq.pop_front());
        if (eng_tmo) begin m_rep = 1; m_err = 3; mq.delete(); end
        else if (eng_nack) begin m_rep = 1; m_err = 2; mq.delete(); end
        else if (mq.size() > 0) begin m_issue = 1; m_first = 0; end
        else begin m_rep = 1; m_err = 0; end
      end
    end else if (!m_busy && req_valid) begin
      m_busy = 1;
      if (req_addr < 12'h080) begin
        if ((req_addr & 12'h078) == 12'h078) begin m_rep = 1; m_err = 1; end
        else begin
          mq.push_back(8'((int'(req_addr) << 1) | int'(req_rd)));
          m_issue = 1; m_first = 1;
        end
      end else if (req_addr < 12'h400) begin
        w16 = (int'(req_addr) << 1) | int'(req_rd) | 'hF000;
        mq.push_back(8'(w16 >> 8));
        mq.push_back(8'(w16));
        m_issue = 1; m_first = 1;
      end else begin
        m_rep = 1; m_err = 1;
      end
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_busy, "R1 req_ready", req_ready, !m_busy);
      chk(eng_cmd_valid == m_issue, "R8 eng_cmd_valid", eng_cmd_valid, m_issue);
      chk(eng_cmd_stop == 1'b0, "R6 eng_cmd_stop", eng_cmd_stop, 0);
      if (m_issue) begin
        chk(eng_cmd_byte == mq[0], "R2/R5 eng_cmd_byte", eng_cmd_byte, mq[0]);
        chk(eng_cmd_start == m_first, "R5 eng_cmd_start", eng_cmd_start, m_first);
      end
      chk(done == m_rep, "R11 done", done, m_rep);
      chk(err_inval == (m_rep && m_err == 1), "R10 err_inval", err_inval, m_rep && m_err == 1);
      chk(err_nack == (m_rep && m_err == 2), "R10 err_nack", err_nack, m_rep && m_err == 2);
      chk(err_tmo == (m_rep && m_err == 3), "R10 err_tmo", err_tmo, m_rep && m_err == 3);
    end
  end

  // Engine responder.
  int stall_cfg, dly_cfg, nack_at = -1, tmo_at = -1;
  int resp_idx, hs_cnt;

  always @(posedge clk) if (rst_n && eng_cmd_valid && eng_cmd_ready) hs_cnt++;

  initial begin
    int phase = 0;
    int cnt = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_nack = 0; eng_tmo = 0;
      if (phase == 0) begin
        if (eng_cmd_valid) begin
          if (cnt >= stall_cfg) begin eng_cmd_ready = 1; phase = 1; cnt = 0; end
          else cnt++;
        end
      end else if (phase == 1) begin
        eng_cmd_ready = 0; phase = 2; cnt = 0;
      end else begin
        if (cnt >= dly_cfg) begin
          eng_done = 1;
          eng_nack = (resp_idx == nack_at);
          eng_tmo  = (resp_idx == tmo_at);
          resp_idx++; phase = 0; cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic run(input int addr, input bit rd, input int stall, input int dly,
                     input int nk, input int tm, input int exp_cmds, input bit poke,
                     input string tag);
    stall_cfg = stall; dly_cfg = dly; nack_at = nk; tmo_at = tm;
    resp_idx = 0; hs_cnt = 0;
    @(negedge clk);
    req_addr = 12'(addr); req_rd = rd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 300; i++) begin
      if (done) break;
      if (poke && i == 1) begin req_addr = 12'h010; req_valid = 1; end
      else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    chk(hs_cnt == exp_cmds, tag, hs_cnt, exp_cmds);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && eng_cmd_valid == 0 && done == 0, "R1 reset state",
        {req_ready, eng_cmd_valid, done}, 3'b100);
    rst_n = 1;
    // 7-bit forms
    run('h050, 0, 0, 0, -1, -1, 1, 0, "R2 7-bit write command count");
    run('h01A, 1, 3, 2, -1, -1, 1, 0, "R2 R7 7-bit read with stall");
    run('h077, 1, 0, 1, -1, -1, 1, 0, "R2 top non-reserved 7-bit");
    run('h000, 0, 1, 0, -1, -1, 1, 1, "R1 busy request ignored");
    // reserved and out of range
    run('h078, 0, 0, 0, -1, -1, 0, 0, "R3 reserved low edge");
    run('h07F, 1, 0, 0, -1, -1, 0, 0, "R3 reserved high edge");
    run('h400, 0, 0, 0, -1, -1, 0, 0, "R4 first out-of-range");
    run('hFFF, 1, 0, 0, -1, -1, 0, 0, "R4 max input");
    // 10-bit forms
    run('h080, 1, 0, 0, -1, -1, 2, 0, "R5 lowest 10-bit");
    run('h3FF, 0, 2, 3, -1, -1, 2, 1, "R5 R7 highest 10-bit stalled");
    run('h2A5, 1, 1, 1, -1, -1, 2, 0, "R5 mixed 10-bit");
    // error paths
    run('h155, 0, 0, 1, 0, -1, 1, 0, "R9 nack on first byte aborts");
    run('h155, 1, 1, 0, -1, 0, 1, 0, "R9 timeout on first byte aborts");
    run('h300, 0, 0, 0, 0, 0, 1, 0, "R10 timeout wins over nack");
    run('h1C3, 0, 0, 2, 1, -1, 2, 0, "R9 nack on second byte");
    run('h033, 0, 2, 0, 0, -1, 1, 0, "R10 7-bit nack");
    run('h045, 1, 0, 0, -1, 0, 1, 0, "R10 7-bit timeout");
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule